// File: doc/BRIEF.md
# Two-Class Priority Flit Arbiter

This block picks one winner per cycle among the virtual channels that request a router's switch or virtual-channel allocation. Each request carries a class bit that marks it as either primary traffic (core and memory requests) or background compute traffic (instruction or data flits of an in-network compute engine). A runtime switch chooses between two policies. With the switch off, every requester takes its turn in one round-robin ring and the class bit is ignored. With the switch on, primary requests beat compute requests outright, and a separate round-robin ring runs inside each class, so compute traffic only fills the cycles that primary traffic leaves idle.

To keep compute traffic from waiting forever behind a steady primary load, a programmable starvation limit lets a blocked compute request win one grant after a set number of lost cycles. A limit of zero turns this escape off. The grant is combinational from the current request and class vectors; the ring pointers and the starvation counter advance on the clock edge that ends the cycle. The default size is eight requesters, for example two input ports with four virtual channels each.

Top module: `prio_flit_arb`

## Requirements
- R1: With no request asserted the grant vector is all zero; after reset all ring pointers start at requester 0, so the first grant in plain mode with every request set goes to requester 0.
- R2: The grant vector has at most one bit set, only on an asserted request, and whenever any request is asserted exactly one bit is set.
- R3: With the priority switch low, grants follow one round-robin ring over all requesters: the winner is the first asserted request at or after one past the previous winner of any class, wrapping from N-1 to 0, regardless of class bits.
- R4: With the priority switch high and no promotion due, a requester whose class bit is 1 (primary) is granted whenever at least one such request is asserted.
- R5: With the priority switch high, each class keeps its own ring pointer, which moves to one past the granted requester only in cycles where that class wins.
- R6: With the priority switch high, a requester whose class bit is 0 (compute) is granted only in cycles with no primary request asserted, or when a promotion is due.
- R7: While the switch is high, a counter counts consecutive cycles in which a compute request was asserted but not granted; it clears whenever a compute request wins, no compute request is asserted or the switch is low, and it saturates at its top value. When the limit is non-zero and the count has reached it, the compute ring wins the current cycle. A limit of zero never promotes.
- R8: Toggling the priority switch changes the policy from the same cycle on and leaves all ring pointers as they were: all three pointers keep tracking grants in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request per requester |
| cls | input | N | Class per requester: 1 primary, 0 compute |
| prio_en | input | 1 | Strict class priority on when high |
| starve_limit | input | CW | Blocked cycles before a compute promotion; 0 disables |
| grant | output | N | One-hot grant, all zero when idle |

## Verification
The assertions take the request and class vectors, the switch and the limit as settled values for the whole cycle, sampled only at the rising edge, and a class bit is only meaningful on an asserted request. The bench changes every input just after the falling edge and holds it for a full cycle, so each edge sees one coherent set. The stimulus mixes random masks and class patterns with directed runs: a steady primary load against one compute request for the promotion path, mid-run toggles of the switch, and the idle and all-requesting vectors.

// File: rtl/prio_flit_arb.sv
module prio_flit_arb #(
  parameter int N  = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  cls,
  input  logic          prio_en,
  input  logic [CW-1:0] starve_limit,
  output logic [N-1:0]  grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [IW-1:0] ptr_all, ptr_pri, ptr_cmp;
  logic [CW-1:0] blk_cnt;
  logic [N-1:0]  pri_req, cmp_req, pool;
  logic [IW-1:0] start, win;
  logic          found, promote, cmp_won;

  assign pri_req = req & cls;
  assign cmp_req = req & ~cls;
  assign promote = prio_en && (starve_limit != '0) && (|cmp_req) && (blk_cnt >= starve_limit);

  always_comb begin
    if (!prio_en) begin
      pool  = req;
      start = ptr_all;
    end else if ((|pri_req) && !promote) begin
      pool  = pri_req;
      start = ptr_pri;
    end else begin
      pool  = cmp_req;
      start = ptr_cmp;
    end
  end

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(start) + k;
      if (idx >= N) idx = idx - N;
      if (!found && pool[idx]) begin
        found = 1'b1;
        win   = IW'(idx);
      end
    end
  end

  assign grant   = found ? (N'(1) << win) : '0;
  assign cmp_won = found && !cls[win];

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (int'(i) == N - 1) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_all <= '0;
      ptr_pri <= '0;
      ptr_cmp <= '0;
      blk_cnt <= '0;
    end else begin
      if (found) begin
        ptr_all <= nxt(win);
        if (cls[win]) ptr_pri <= nxt(win);
        else          ptr_cmp <= nxt(win);
      end
      if (prio_en && (|cmp_req) && !cmp_won)
        blk_cnt <= (blk_cnt == CNT_MAX) ? blk_cnt : blk_cnt + 1'b1;
      else
        blk_cnt <= '0;
    end
  end
endmodule

// File: rtl/prio_flit_arb_chk.sv
module prio_flit_arb_chk #(
  parameter int N  = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic [N-1:0]  cls,
  input logic          prio_en,
  input logic [CW-1:0] starve_limit,
  input logic [N-1:0]  grant
);
  logic [CW-1:0] lost;
  logic          cmp_pend, cmp_got;

  assign cmp_pend = |(req & ~cls);
  assign cmp_got  = |(grant & ~cls);

  always_ff @(posedge clk) begin
    if (!rst_n) lost <= '0;
    else if (prio_en && cmp_pend && !cmp_got) lost <= (&lost) ? lost : lost + 1'b1;
    else lost <= '0;
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  a_r2_subset: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~req) == '0);
  a_r2_busy:   assert property (@(posedge clk) disable iff (!rst_n) (|req) |-> $countones(grant) == 1);
  a_r1_idle:   assert property (@(posedge clk) disable iff (!rst_n) (req == '0) |-> (grant == '0));
  a_r6_block:  assert property (@(posedge clk) disable iff (!rst_n)
                 (prio_en && (starve_limit == '0) && (|(req & cls))) |-> !cmp_got);
  a_r4_primary: assert property (@(posedge clk) disable iff (!rst_n)
                 (prio_en && (|(req & cls)) && (starve_limit == '0)) |-> (|(grant & cls)));
  a_r7_promote: assert property (@(posedge clk) disable iff (!rst_n)
                 (prio_en && cmp_pend && (starve_limit != '0) && (lost >= starve_limit)) |-> cmp_got);
endmodule

bind prio_flit_arb prio_flit_arb_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .cls(cls), .prio_en(prio_en),
  .starve_limit(starve_limit), .grant(grant)
);

// File: tb/prio_flit_arb_test.sv
module prio_flit_arb_test;
  localparam int N  = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  cls = '0;
  logic          prio_en = 1'b0;
  logic [CW-1:0] starve_limit = '0;
  logic [N-1:0]  grant;

  int checks = 0, errors = 0;
  bit done = 0;
  int p_all = 0, p_pri = 0, p_cmp = 0, scnt = 0;

  prio_flit_arb #(.N(N), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .cls(cls), .prio_en(prio_en),
    .starve_limit(starve_limit), .grant(grant)
  );

  always #2.5 clk = ~clk;

  function automatic int pick(input logic [N-1:0] m, input int from);
    for (int k = 0; k < N; k++) if (m[(from + k) % N]) return (from + k) % N;
    return -1;
  endfunction

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] c, input bit en,
                      input int lim, input string tag);
    logic [N-1:0] pm, cm, exp;
    int g;
    bit prom;
    @(negedge clk);
    req = r; cls = c; prio_en = en; starve_limit = CW'(lim);
    #1;
    pm = r & c; cm = r & ~c;
    prom = en && lim != 0 && cm != 0 && scnt >= lim;
    if (!en) g = pick(r, p_all);
    else if (pm != 0 && !prom) g = pick(pm, p_pri);
    else g = pick(cm, p_cmp);
    exp = (g < 0) ? '0 : (N'(1) << g);
    checks++;
    if (grant !== exp) begin
      errors++;
      $display("FAIL %s: grant=%b expected=%b (req=%b cls=%b en=%0d)", tag, grant, exp, r, c, en);
    end
    if (g >= 0) begin
      p_all = (g + 1) % N;
      if (c[g]) p_pri = (g + 1) % N; else p_cmp = (g + 1) % N;
    end
    if (en && cm != 0 && !(g >= 0 && !c[g])) scnt = (scnt < (1 << CW) - 1) ? scnt + 1 : scnt;
    else scnt = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset pointers and idle grant
    step('1, '0, 0, 0, "R1 reset pointer");
    repeat (4) step('0, $urandom, $urandom_range(0, 1), 0, "R1 idle");
    // R3: plain ring ignores class
    for (int i = 0; i < 300; i++) step(N'($urandom), N'($urandom), 0, 0, "R3 plain ring");
    repeat (10) step('1, 8'hA5, 0, 0, "R3 full ring");
    // R4 R5 R6: strict priority, no promotion
    for (int i = 0; i < 300; i++) step(N'($urandom), N'($urandom), 1, 0, "R4 R5 R6 priority");
    repeat (20) step(8'b0000_1110, 8'b0000_0010, 1, 0, "R6 compute blocked");
    repeat (8) step(8'b1100_0000, 8'b0000_0000, 1, 0, "R5 compute ring");
    // R7: promotion with limit 3, then limit 0
    repeat (16) step(8'b0000_0110, 8'b0000_0010, 1, 3, "R7 promotion");
    repeat (8) step(8'b0011_0000, 8'b0001_0000, 1, 1, "R7 limit one");
    for (int i = 0; i < 300; i++) step(N'($urandom), N'($urandom), 1, $urandom_range(0, 4), "R7 random limit");
    repeat (10) step(8'b0000_0110, 8'b0000_0010, 1, 0, "R7 limit zero");
    // R8: switch toggles keep pointers
    for (int i = 0; i < 400; i++)
      step(N'($urandom), N'($urandom), (i / 3) % 2 == 0, $urandom_range(0, 2), "R8 toggle");
    for (int i = 0; i < 200; i++)
      step(N'($urandom), N'($urandom), $urandom_range(0, 1), 0, "R2 R8 mixed");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule